// File: doc/BRIEF.md
# Set/Clear GPIO Controller

This block is a register-mapped general-purpose I/O controller with four pieces of writable state: an output level vector, a drive (direction) vector, a pin-mux vector and a second output vector for a bank of memory-shared pins. None of these is ever written directly. Each has one address that ORs ones into it and another address that clears the bit positions written as one. Software can then change single pins without a read-modify-write sequence. The output, drive and mux vectors are each read back at their own state address.

Pin inputs are synchronised through two flops and then gathered into two input-state words, one for the main bank and one for the shared bank. Six bidirectional pins (25 to 30) report their levels at other positions in the main input-state word. Six pins take their mux control from scattered bits of the mux vector. A pin switched to its alternate function is driven from an alternate-function input and has its output enable removed.

The register bus is a plain synchronous one. Writes take effect at the clock edge on which `busWe` is high. Read data is a combinational function of `busAddr` and the current state.

Top module: `gpio_sc_top`

## Requirements
- R1: After reset the output, drive, mux and shared-output vectors are all zero, so `pinOe`, `pinOut`, `shOe` and `shOut` are zero.
- R2: A write to a set address ORs the written data into its vector: 0x04 for output, 0x10 for drive, 0x28 for mux and 0x20 for shared output. Bits written as zero leave the vector unchanged.
- R3: A write to a clear address clears the bits written as one and keeps all other bits: 0x08 for output, 0x14 for drive, 0x2C for mux and 0x24 for shared output.
- R4: Only the byte addresses 0x00, 0x0C, 0x18, 0x1C and 0x30 return data. A read of any other address returns zero. A write to one of these five read addresses, or to any address that is not a set or clear address, changes no state.
- R5: Reading 0x0C, 0x18 and 0x30 returns the output, drive and mux vectors.
- R6: Reading 0x00 returns `inPins` after two clock edges of synchronisation. Bits 10, 11, 12, 13, 14 and 24 are the exception: they carry `bidirIn[0]` to `bidirIn[5]`, which are the levels of bidirectional pins 25 to 30.
- R7: Reading 0x1C returns `shIn` after two clock edges of synchronisation. A change is not visible after only one edge.
- R8: Pins 27, 28, 29, 30, 3 and 21 are muxed by mux-vector bits 0, 1, 4, 5, 6 and 2, in that pairing. All other pins are never muxed.
- R9: For each pin, `pinOe` = drive AND NOT muxed. `pinOut` equals `altIn` for a muxed pin and the output vector bit otherwise.
- R10: `shOe` equals the drive vector and `shOut` equals the shared-output vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| inPins | input | 32 | Main-bank input levels |
| bidirIn | input | 6 | Levels of bidirectional pins 25..30 |
| shIn | input | 32 | Shared-bank input levels |
| altIn | input | 32 | Alternate-function output values |
| pinOut | output | 32 | Main-bank output values |
| pinOe | output | 32 | Main-bank output enables |
| shOut | output | 32 | Shared-bank output values |
| shOe | output | 32 | Shared-bank output enables |

## Verification
A pin input change can arrive in the same cycle as a bus write that changes output or drive state. The bench changes `inPins`, `bidirIn` and `shIn` on the falling edge that starts a write. It then checks that each input-state word still holds the old value after one edge and the new value after two, while the written vector has changed after one edge. The mux sweep sets each mux bit while drive and output are fixed non-zero patterns, so that both the output-enable removal and the output source switch can be judged against a bench-side map in the same cycle.

// File: rtl/gpio_sc_pkg.sv
`timescale 1ns/1ps
package gpio_sc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_IN_STATE  = 8'h00;
  localparam logic [ADDR_W-1:0] A_OUT_SET   = 8'h04;
  localparam logic [ADDR_W-1:0] A_OUT_CLR   = 8'h08;
  localparam logic [ADDR_W-1:0] A_OUT_STATE = 8'h0C;
  localparam logic [ADDR_W-1:0] A_DRV_SET   = 8'h10;
  localparam logic [ADDR_W-1:0] A_DRV_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] A_DRV_STATE = 8'h18;
  localparam logic [ADDR_W-1:0] A_SH_IN     = 8'h1C;
  localparam logic [ADDR_W-1:0] A_SH_SET    = 8'h20;
  localparam logic [ADDR_W-1:0] A_SH_CLR    = 8'h24;
  localparam logic [ADDR_W-1:0] A_MUX_SET   = 8'h28;
  localparam logic [ADDR_W-1:0] A_MUX_CLR   = 8'h2C;
  localparam logic [ADDR_W-1:0] A_MUX_STATE = 8'h30;

  // bidirectional pins whose levels are folded into the input word
  localparam int NUM_BIDIR = 6;
  localparam int BIDIR_FIRST_PIN = 25;
  localparam int BIDIR_IN_POS [NUM_BIDIR] = '{10, 11, 12, 13, 14, 24};

  // pins that follow a scattered mux-vector bit
  localparam int NUM_MUXED = 6;
  localparam int MUXED_PIN [NUM_MUXED] = '{27, 28, 29, 30, 3, 21};
  localparam int MUXED_BIT [NUM_MUXED] = '{0, 1, 4, 5, 6, 2};

  typedef struct packed {
    logic outSet;
    logic outClr;
    logic drvSet;
    logic drvClr;
    logic shSet;
    logic shClr;
    logic muxSet;
    logic muxClr;
  } wrStrobe_t;

  typedef enum logic [2:0] {
    RD_ZERO, RD_IN, RD_OUT, RD_DRV, RD_SHIN, RD_MUX
  } rdSel_t;

  function automatic logic [DATA_W-1:0] applySetClr(
    input logic [DATA_W-1:0] cur, input logic doSet, input logic doClr,
    input logic [DATA_W-1:0] data);
    if (doSet)      return cur | data;
    else if (doClr) return cur & ~data;
    else            return cur;
  endfunction
endpackage

// File: rtl/gpio_sc_sync.sv
`timescale 1ns/1ps
module gpio_sc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES+1];
  assign chain[0] = d;

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/gpio_sc_ctrl.sv
`timescale 1ns/1ps
module gpio_sc_ctrl
  import gpio_sc_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output wrStrobe_t         strobe,
  output rdSel_t            rdSel
);
  always_comb begin
    strobe = '0;
    rdSel  = RD_ZERO;
    unique case (busAddr)
      A_IN_STATE:  rdSel = RD_IN;
      A_OUT_STATE: rdSel = RD_OUT;
      A_DRV_STATE: rdSel = RD_DRV;
      A_SH_IN:     rdSel = RD_SHIN;
      A_MUX_STATE: rdSel = RD_MUX;
      A_OUT_SET:   strobe.outSet = busWe;
      A_OUT_CLR:   strobe.outClr = busWe;
      A_DRV_SET:   strobe.drvSet = busWe;
      A_DRV_CLR:   strobe.drvClr = busWe;
      A_SH_SET:    strobe.shSet  = busWe;
      A_SH_CLR:    strobe.shClr  = busWe;
      A_MUX_SET:   strobe.muxSet = busWe;
      A_MUX_CLR:   strobe.muxClr = busWe;
      default:     rdSel = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/gpio_sc_datapath.sv
`timescale 1ns/1ps
module gpio_sc_datapath
  import gpio_sc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] inPins,
  input  logic [NUM_BIDIR-1:0] bidirIn,
  input  logic [DATA_W-1:0] shIn,
  input  logic [DATA_W-1:0] altIn,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  output logic [DATA_W-1:0] shOut,
  output logic [DATA_W-1:0] shOe
);
  logic [DATA_W-1:0] outVec, drvVec, muxVec, shVec;
  logic [DATA_W-1:0] inSync, shSync, inWord, pinMux;
  logic [NUM_BIDIR-1:0] bidirSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outVec <= '0;
      drvVec <= '0;
      muxVec <= '0;
      shVec  <= '0;
    end else begin
      outVec <= applySetClr(outVec, strobe.outSet, strobe.outClr, wdata);
      drvVec <= applySetClr(drvVec, strobe.drvSet, strobe.drvClr, wdata);
      muxVec <= applySetClr(muxVec, strobe.muxSet, strobe.muxClr, wdata);
      shVec  <= applySetClr(shVec,  strobe.shSet,  strobe.shClr,  wdata);
    end
  end

  gpio_sc_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_syncIn (
    .clk(clk), .rstN(rstN), .d(inPins), .q(inSync));
  gpio_sc_sync #(.WIDTH(NUM_BIDIR), .STAGES(SYNC_STAGES)) u_syncBidir (
    .clk(clk), .rstN(rstN), .d(bidirIn), .q(bidirSync));
  gpio_sc_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_syncSh (
    .clk(clk), .rstN(rstN), .d(shIn), .q(shSync));

  // fold bidirectional pin levels into their input-word positions
  always_comb begin
    inWord = inSync;
    for (int i = 0; i < NUM_BIDIR; i++) inWord[BIDIR_IN_POS[i]] = bidirSync[i];
  end

  // per-pin mux view from scattered mux-vector bits
  always_comb begin
    pinMux = '0;
    for (int i = 0; i < NUM_MUXED; i++) pinMux[MUXED_PIN[i]] = muxVec[MUXED_BIT[i]];
  end

  assign pinOe  = drvVec & ~pinMux;
  assign pinOut = (altIn & pinMux) | (outVec & ~pinMux);
  assign shOe   = drvVec;
  assign shOut  = shVec;

  always_comb begin
    unique case (rdSel)
      RD_IN:   rdata = inWord;
      RD_OUT:  rdata = outVec;
      RD_DRV:  rdata = drvVec;
      RD_SHIN: rdata = shSync;
      RD_MUX:  rdata = muxVec;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_sc_top.sv
`timescale 1ns/1ps
module gpio_sc_top
  import gpio_sc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [DATA_W-1:0]    inPins,
  input  logic [NUM_BIDIR-1:0] bidirIn,
  input  logic [DATA_W-1:0]    shIn,
  input  logic [DATA_W-1:0]    altIn,
  output logic [DATA_W-1:0]    pinOut,
  output logic [DATA_W-1:0]    pinOe,
  output logic [DATA_W-1:0]    shOut,
  output logic [DATA_W-1:0]    shOe
);
  wrStrobe_t strobe;
  rdSel_t    rdSel;

  gpio_sc_ctrl u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .strobe(strobe), .rdSel(rdSel));

  gpio_sc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel),
    .wdata(busWdata), .inPins(inPins), .bidirIn(bidirIn), .shIn(shIn),
    .altIn(altIn), .rdata(busRdata), .pinOut(pinOut), .pinOe(pinOe),
    .shOut(shOut), .shOe(shOe));
endmodule

// File: rtl/gpio_sc_checker.sv
`timescale 1ns/1ps
module gpio_sc_checker
  import gpio_sc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [DATA_W-1:0] pinOe,
  input logic [DATA_W-1:0] shOut,
  input logic [DATA_W-1:0] shOe
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOe == '0 && shOe == '0 && shOut == '0));

  a_r2_drive_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_DRV_SET) |=> ((shOe & $past(busWdata)) == $past(busWdata)));

  a_r2_shared_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_SH_SET) |=> ((shOut & $past(busWdata)) == $past(busWdata)));

  a_r3_drive_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_DRV_CLR) |=> ((shOe & $past(busWdata)) == '0));

  a_r4_state_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_DRV_STATE) |=> $stable(shOe));

  a_r4_set_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_OUT_SET || busAddr == A_MUX_CLR || busAddr == A_SH_SET) |-> busRdata == '0);

  a_r9_oe_needs_drive: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & ~shOe) == '0);
endmodule

bind gpio_sc_top gpio_sc_checker u_chk (.*);

// File: tb/tb_gpio_sc_top.sv
`timescale 1ns/1ps
module tb_gpio_sc_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic [31:0] inPins = '0, shIn = '0, altIn = '0;
  logic [5:0] bidirIn = '0;
  logic [31:0] pinOut, pinOe, shOut, shOe;

  int total = 0;
  int bad = 0;
  logic [31:0] mOut = '0, mDrv = '0, mMux = '0, mSh = '0;

  always #2.5 clk = ~clk;

  gpio_sc_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  function automatic logic [31:0] muxMap(input logic [31:0] m);
    logic [31:0] r = '0;
    r[27] = m[0]; r[28] = m[1]; r[29] = m[4];
    r[30] = m[5]; r[3] = m[6]; r[21] = m[2];
    return r;
  endfunction

  function automatic logic [31:0] inMap(input logic [31:0] p, input logic [5:0] b);
    logic [31:0] r = p;
    r[10] = b[0]; r[11] = b[1]; r[12] = b[2];
    r[13] = b[3]; r[14] = b[4]; r[24] = b[5];
    return r;
  endfunction

  task automatic checkAll(input string req);
    logic [31:0] v;
    rd(8'h0C, v); chk({req, " R5 out"}, v, mOut);
    rd(8'h18, v); chk({req, " R5 drv"}, v, mDrv);
    rd(8'h30, v); chk({req, " R5 mux"}, v, mMux);
    chk({req, " R10 shOut"}, shOut, mSh);
    chk({req, " R10 shOe"}, shOe, mDrv);
    chk({req, " R9 pinOe"}, pinOe, mDrv & ~muxMap(mMux));
    chk({req, " R9 pinOut"}, pinOut, (altIn & muxMap(mMux)) | (mOut & ~muxMap(mMux)));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    logic [7:0] addrs [4][2];
    addrs[0] = '{8'h04, 8'h08}; addrs[1] = '{8'h10, 8'h14};
    addrs[2] = '{8'h28, 8'h2C}; addrs[3] = '{8'h20, 8'h24};
    altIn = 32'hC3A5_5A3C;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pinOe", pinOe, '0);
    chk("R1 pinOut", pinOut, '0);
    chk("R1 shOe", shOe, '0);
    chk("R1 shOut", shOut, '0);
    checkAll("R1");

    // R2 / R3 walking set then clear on every vector
    for (int r = 0; r < 4; r++) begin
      for (int b = 0; b < 32; b++) begin
        wr(addrs[r][0], 32'h1 << b);
        case (r) 0: mOut |= 32'h1 << b; 1: mDrv |= 32'h1 << b;
                 2: mMux |= 32'h1 << b; default: mSh |= 32'h1 << b; endcase
        checkAll("R2 walk set");
      end
      for (int b = 0; b < 32; b += 3) begin
        wr(addrs[r][1], 32'h1 << b);
        case (r) 0: mOut &= ~(32'h1 << b); 1: mDrv &= ~(32'h1 << b);
                 2: mMux &= ~(32'h1 << b); default: mSh &= ~(32'h1 << b); endcase
        checkAll("R3 walk clear");
      end
      wr(addrs[r][1], 32'h0);
      checkAll("R3 zero clear");
      wr(addrs[r][0], 32'h0);
      checkAll("R2 zero set");
    end
    // mixed patterns
    pat = 32'hA5A5_0F0F;
    for (int r = 0; r < 4; r++) begin
      wr(addrs[r][1], 32'hFFFF_FFFF);
      wr(addrs[r][0], pat);
      wr(addrs[r][1], 32'h0FF0_00F0);
      case (r) 0: mOut = pat & ~32'h0FF0_00F0; 1: mDrv = pat & ~32'h0FF0_00F0;
               2: mMux = pat & ~32'h0FF0_00F0; default: mSh = pat & ~32'h0FF0_00F0; endcase
      checkAll("R3 mixed");
    end

    // R4 unmapped reads and ignored writes
    for (int a = 0; a < 256; a++) begin
      if (a != 'h00 && a != 'h0C && a != 'h18 && a != 'h1C && a != 'h30) begin
        rd(a[7:0], v); chk("R4 read zero", v, '0);
      end
    end
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF); wr(8'hFC, 32'h0);
    checkAll("R4 ignored writes");

    // R8 / R9 mux sweep with drive all on
    wr(8'h10, 32'hFFFF_FFFF); mDrv = 32'hFFFF_FFFF;
    wr(8'h2C, 32'hFFFF_FFFF); mMux = '0;
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h04, 32'h1234_5678); mOut = 32'h1234_5678;
    for (int b = 0; b < 32; b++) begin
      wr(8'h28, 32'h1 << b); mMux = 32'h1 << b;
      chk("R8 muxed pins", pinOe, ~muxMap(mMux));
      checkAll("R9 mux sweep");
      wr(8'h2C, 32'h1 << b); mMux = '0;
    end

    // R6 / R7 synchronised inputs, changed while a write lands
    for (int k = 0; k < 8; k++) begin
      logic [31:0] oldIn, oldSh, nIn, nSh;
      logic [5:0] oldB, nB;
      oldIn = inPins; oldSh = shIn; oldB = bidirIn;
      nIn = 32'h9E37_79B9 * (k + 1); nSh = ~nIn ^ (32'h1 << k);
      nB = 6'(k * 11 + 5);
      @(negedge clk);
      inPins = nIn; shIn = nSh; bidirIn = nB;
      busAddr = 8'h04; busWe = 1'b1; busWdata = 32'h1 << (k + 8);
      mOut |= 32'h1 << (k + 8);
      @(negedge clk);
      busWe = 1'b0;
      rd(8'h00, v); chk("R6 one edge old", v, inMap(oldIn, oldB));
      rd(8'h1C, v); chk("R7 one edge old", v, oldSh);
      rd(8'h0C, v); chk("R2 write with input change", v, mOut);
      @(negedge clk);
      rd(8'h00, v); chk("R6 two edges new", v, inMap(nIn, nB));
      rd(8'h1C, v); chk("R7 two edges new", v, nSh);
    end

    // R1 reset again clears all vectors
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    mOut = '0; mDrv = '0; mMux = '0; mSh = '0;
    checkAll("R1 re-reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule